// File: doc/BRIEF.md
# Same-ID Ordering Stall Tracker

This block sits on the address channel of one direction, read or write, of one upstream port of a switch fabric. It counts the transactions that are still open for each ID value and remembers which downstream target those transactions went to. A new request whose ID matches open transactions headed to a different target is held off until those transactions finish. Because of this, responses for any one ID always come back from a single target, and the fabric never has to reorder them.

Only the low `ID_USED` bits of an ID pick a tracking entry. IDs that differ only in their upper bits therefore share an entry. They conflict with each other even though the protocol does not require it, and in return the table is smaller. The block also limits the number of transactions open on the port. It sits between the upstream address channel and the downstream one: it gates valid towards the target and ready back towards the requester. A completion event (the last read data beat, or a write response) with its ID frees one transaction.

Top module: `id_order_gate`

## Requirements
- R1: After reset every entry count and the port total are zero, so a first request with any ID and target passes with `req_valid_o == req_valid_i` and `req_ready_o == req_ready_i`.
- R2: A request whose entry has a nonzero count and a stored target different from `req_tgt_i` is stalled: `req_valid_o` and `req_ready_o` are both 0 in that cycle.
- R3: A request to the stored target of its entry passes while the entry count is below `MAX_PER_ID`, and is stalled when the count equals `MAX_PER_ID` (default 3).
- R4: Only bits `[ID_USED-1:0]` of the ID select an entry (default `ID_USED`=2 of `ID_W`=4). IDs that differ only in upper bits conflict under R2 and R3.
- R5: Requests whose low ID bits differ use separate entries and do not stall each other under R2 or R3.
- R6: When the number of open transactions on the port equals `MAX_TOTAL` (default 6), every request is stalled.
- R7: A completion (`cpl_valid_i` with `cpl_id_i`) lowers the count of its entry and the port total by one from the next cycle. Once an entry count is zero, a request to any target is accepted and becomes the entry's new stored target.
- R8: An accepted request and a completion on the same entry in the same cycle leave that entry's count and the port total unchanged.
- R9: Gating is combinational: `req_valid_o = req_valid_i & !stall` and `req_ready_o = req_ready_i & !stall`. A transaction counts as accepted only when `req_valid_i`, `req_ready_i` and no stall hold together. An unaccepted request changes no state.
- R10: Synchronous active-low `rst_n` clears all counts at a rising edge, so a request that was stalling before reset is accepted right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Upstream address request valid |
| req_id_i | input | ID_W | ID of the request |
| req_tgt_i | input | TGT_W | Decoded downstream target index |
| req_ready_o | output | 1 | Ready returned to upstream, gated by the stall |
| req_valid_o | output | 1 | Valid forwarded downstream, gated by the stall |
| req_ready_i | input | 1 | Ready from downstream |
| cpl_valid_i | input | 1 | One transaction completes this cycle |
| cpl_id_i | input | ID_W | ID of the completing transaction |

## Verification
The gated valid and ready respond combinationally, in the same cycle as the request and the current table state. The effect of an accept or a completion on later stall decisions first appears in the cycle after the rising edge that registers it. The bench therefore drives every input on the falling edge and samples the gated outputs 1 ns later. It updates its arithmetic model of per-entry counts, stored targets and the port total only after the following rising edge. Each check then compares the outputs against the model state that the RTL holds at that moment. Directed sequences cover conflicts, upper-bit aliasing, both caps, the same-cycle accept and completion case and a mid-run reset. A long pseudo-random sweep over all IDs, targets and handshake combinations follows.

// File: rtl/id_order_pkg.sv
// Shared helpers for the same-ID ordering stall tracker.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package id_order_pkg;

    // Index width for n choices, never below one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Counter width able to hold the values 0..max inclusive.
    function automatic int unsigned cnt_width(input int unsigned max);
        return (max > 0) ? $clog2(max + 1) : 1;
    endfunction

endpackage

// File: rtl/id_order_entry.sv
// One tracking entry: an open-transaction counter and the target index
// the open transactions were sent to.
// Assumes the caller never raises inc_i at MAX (the gate stalls first)
// and never raises dec_i while the count is zero.
module id_order_entry #(
    parameter int unsigned MAX   = 3,
    parameter int unsigned CNT_W = 2,
    parameter int unsigned TGT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic [TGT_W-1:0] tgt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [TGT_W-1:0] tgt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX);

    logic [CNT_W-1:0] cnt_q;
    logic [TGT_W-1:0] tgt_q;

    // Count up on accept, down on completion, hold when both happen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc_i && !dec_i) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec_i && !inc_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Record the target of every accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (inc_i) begin
            tgt_q <= tgt_i;
        end
    end

    assign cnt_o = cnt_q;
    assign tgt_o = tgt_q;

    // R3: the entry never goes past its limit.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |-> (cnt_q != CNT_MAX));

    // R7: a completion only arrives for an open transaction.
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i) |-> (cnt_q != '0));

    // R8: simultaneous accept and completion keep the count.
    a_r8_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i) |=> $stable(cnt_q));

    // R7: an accept stores its target for later comparisons.
    a_r7_target_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> (tgt_q == $past(tgt_i)));

endmodule

// File: rtl/id_order_total.sv
// Port-wide count of open transactions, used to cap the outstanding total.
// Assumes inc_i is withheld at MAX and dec_i only arrives for an open one.
module id_order_total #(
    parameter int unsigned MAX   = 6,
    parameter int unsigned TOT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [TOT_W-1:0] tot_o,
    output logic             full_o
);

    localparam logic [TOT_W-1:0] TOT_MAX = TOT_W'(MAX);

    logic [TOT_W-1:0] tot_q;

    // Track accepted minus completed transactions on the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tot_q <= '0;
        end else if (inc_i && !dec_i) begin
            tot_q <= tot_q + 1'b1;
        end else if (dec_i && !inc_i) begin
            tot_q <= tot_q - 1'b1;
        end
    end

    assign tot_o  = tot_q;
    assign full_o = (tot_q == TOT_MAX);

    // R6: the port total never exceeds its cap.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |-> (tot_q != TOT_MAX));

    // R7: the total cannot drop below zero.
    a_r7_total_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i) |-> (tot_q != '0));

endmodule

// File: rtl/id_order_gate.sv
// Same-ID ordering stall tracker for one direction of one upstream port.
// Holds off an address request whose low ID bits match open transactions
// sent to another target, or that would exceed the per-ID or per-port
// limit. Gates valid downstream and ready upstream in the same cycle.
// Assumes completions only name IDs with open transactions.
module id_order_gate
    import id_order_pkg::*;
#(
    parameter int unsigned ID_W       = 4,
    parameter int unsigned ID_USED    = 2,
    parameter int unsigned NUM_TGT    = 4,
    parameter int unsigned MAX_PER_ID = 3,
    parameter int unsigned MAX_TOTAL  = 6,
    localparam int unsigned TGT_W     = idx_width(NUM_TGT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [ID_W-1:0]  req_id_i,
    input  logic [TGT_W-1:0] req_tgt_i,
    output logic             req_ready_o,
    output logic             req_valid_o,
    input  logic             req_ready_i,
    input  logic             cpl_valid_i,
    input  logic [ID_W-1:0]  cpl_id_i
);

    localparam int unsigned NUM_ENT = 1 << ID_USED;
    localparam int unsigned CNT_W   = cnt_width(MAX_PER_ID);
    localparam int unsigned TOT_W   = cnt_width(MAX_TOTAL);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PER_ID);

    initial begin
        if (ID_USED == 0 || ID_USED > ID_W) begin
            $error("ID_USED must lie in 1..ID_W");
        end
    end

    logic [ID_USED-1:0] req_idx;
    logic [ID_USED-1:0] cpl_idx;
    logic [CNT_W-1:0]   ent_cnt [NUM_ENT];
    logic [TGT_W-1:0]   ent_tgt [NUM_ENT];
    logic [TOT_W-1:0]   tot;
    logic               tot_full;
    logic               other_tgt;
    logic               id_full;
    logic               stall;
    logic               accept;

    assign req_idx = req_id_i[ID_USED-1:0];
    assign cpl_idx = cpl_id_i[ID_USED-1:0];

    // Upper ID bits take no part in the tracking.
    if (ID_W > ID_USED) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^{req_id_i[ID_W-1:ID_USED], cpl_id_i[ID_W-1:ID_USED]};
    end

    // Decide whether the presented request must wait.
    always_comb begin
        other_tgt = (ent_cnt[req_idx] != '0) && (ent_tgt[req_idx] != req_tgt_i);
        id_full   = (ent_cnt[req_idx] == CNT_MAX);
        stall     = other_tgt || id_full || tot_full;
    end

    assign req_valid_o = req_valid_i && !stall;
    assign req_ready_o = req_ready_i && !stall;
    assign accept      = req_valid_i && req_ready_i && !stall;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        id_order_entry #(
            .MAX   (MAX_PER_ID),
            .CNT_W (CNT_W),
            .TGT_W (TGT_W)
        ) u_entry (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (accept && (req_idx == ID_USED'(i))),
            .dec_i (cpl_valid_i && (cpl_idx == ID_USED'(i))),
            .tgt_i (req_tgt_i),
            .cnt_o (ent_cnt[i]),
            .tgt_o (ent_tgt[i])
        );
    end

    id_order_total #(
        .MAX   (MAX_TOTAL),
        .TOT_W (TOT_W)
    ) u_total (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (accept),
        .dec_i  (cpl_valid_i),
        .tot_o  (tot),
        .full_o (tot_full)
    );

    // Sum of entry counts, compared with the separate port total.
    logic [TOT_W+CNT_W+ID_USED-1:0] ent_sum;
    always_comb begin
        ent_sum = '0;
        for (int k = 0; k < NUM_ENT; k++) begin
            ent_sum = ent_sum + (TOT_W+CNT_W+ID_USED)'(ent_cnt[k]);
        end
    end

    // R6: the port total and the per-entry counts stay consistent.
    a_r6_total_matches: assert property (@(posedge clk) disable iff (!rst_n)
        ent_sum == (TOT_W+CNT_W+ID_USED)'(tot));

    // R2: after an accept, its entry is open towards the accepted target.
    a_r2_entry_open: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(cpl_valid_i && cpl_idx == req_idx))
        |=> (ent_cnt[$past(req_idx)] != '0) && (ent_tgt[$past(req_idx)] == $past(req_tgt_i)));

    // R9: nothing goes downstream without an upstream request.
    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |-> !req_valid_o);

    // R9: an unaccepted request leaves the port total untouched.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req_valid_o && req_ready_i) && !cpl_valid_i) |=> $stable(tot));

endmodule

// File: tb/id_order_gate_bench.sv
// Self-checking bench: arithmetic model of counts, targets and total.
module id_order_gate_bench;

    localparam int ID_W = 4, ID_USED = 2, NUM_TGT = 4;
    localparam int MAXID = 3, MAXTOT = 6, NENT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid_i = 1'b0;
    logic [3:0] req_id_i = '0;
    logic [1:0] req_tgt_i = '0;
    logic       req_ready_o, req_valid_o;
    logic       req_ready_i = 1'b0;
    logic       cpl_valid_i = 1'b0;
    logic [3:0] cpl_id_i = '0;

    int checks = 0;
    int fails  = 0;
    int m_cnt [NENT];
    int m_tgt [NENT];
    int m_tot;

    always #10 clk = ~clk;

    id_order_gate #(
        .ID_W(ID_W), .ID_USED(ID_USED), .NUM_TGT(NUM_TGT),
        .MAX_PER_ID(MAXID), .MAX_TOTAL(MAXTOT)
    ) u_id_order_gate (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_id_i(req_id_i), .req_tgt_i(req_tgt_i),
        .req_ready_o(req_ready_o), .req_valid_o(req_valid_o),
        .req_ready_i(req_ready_i),
        .cpl_valid_i(cpl_valid_i), .cpl_id_i(cpl_id_i)
    );

    task automatic model_clear();
        for (int k = 0; k < NENT; k++) begin
            m_cnt[k] = 0;
            m_tgt[k] = 0;
        end
        m_tot = 0;
    endtask

    // One cycle: drive at falling edge, check gating, update model after rise.
    task automatic step(input string tag, input bit v, input int id, input int t,
                        input bit r, input bit cv, input int cid);
        int  e;
        int  ce;
        bit  st;
        bit  acc;
        @(negedge clk);
        req_valid_i = v;  req_id_i = 4'(id);  req_tgt_i = 2'(t);
        req_ready_i = r;  cpl_valid_i = cv;   cpl_id_i = 4'(cid);
        e  = id % NENT;
        ce = cid % NENT;
        st = (m_cnt[e] != 0 && m_tgt[e] != t) || (m_cnt[e] == MAXID) || (m_tot == MAXTOT);
        #1;
        checks++;
        if (req_valid_o !== (v && !st) || req_ready_o !== (r && !st)) begin
            fails++;
            $display("FAIL %s: valid_o=%0b ready_o=%0b expected valid_o=%0b ready_o=%0b",
                     tag, req_valid_o, req_ready_o, v && !st, r && !st);
        end
        acc = v && r && !st;
        @(posedge clk);
        if (acc) begin
            m_cnt[e]++;  m_tgt[e] = t;  m_tot++;
        end
        if (cv) begin
            m_cnt[ce]--; m_tot--;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid_i = 1'b0; cpl_valid_i = 1'b0; req_ready_i = 1'b0;
        repeat (2) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20ns * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        model_clear();
        do_reset();
        // R1: first request passes through.
        step("R1", 1, 0, 0, 1, 0, 0);
        // R2: same ID, other target stalls.
        step("R2", 1, 0, 1, 1, 0, 0);
        // R4: upper bits differ, low bits equal, still conflicts.
        step("R4", 1, 12, 2, 1, 0, 0);
        // R5: different low bits are independent.
        step("R5", 1, 1, 2, 1, 0, 0);
        // R3: same target up to the limit, then stall (id 8 aliases entry 0).
        step("R3", 1, 8, 0, 1, 0, 0);
        step("R3", 1, 0, 0, 1, 0, 0);
        step("R3", 1, 0, 0, 1, 0, 0);
        // R9: no downstream ready, no accept, no state change.
        step("R9", 1, 2, 1, 0, 0, 0);
        step("R9", 0, 2, 1, 1, 0, 0);
        step("R9", 1, 2, 1, 1, 0, 0);
        step("R5", 1, 3, 3, 1, 0, 0);
        // R6: port cap reached (total 6).
        step("R6", 1, 1, 2, 1, 0, 0);
        step("R6", 1, 2, 1, 1, 0, 0);
        // R7: free entry 3, then retarget it.
        step("R7", 0, 0, 0, 0, 1, 3);
        step("R7", 1, 3, 0, 1, 0, 0);
        step("R7", 0, 0, 0, 0, 1, 0);
        // R8: accept and completion on entry 0 together.
        step("R8", 1, 4, 0, 1, 1, 0);
        step("R8", 1, 0, 0, 1, 0, 0);
        step("R8", 0, 0, 0, 0, 1, 3);
        step("R8", 1, 0, 0, 1, 0, 0);
        // R10: reset mid-run clears the conflict.
        do_reset();
        step("R10", 1, 0, 1, 1, 0, 0);
        step("R10", 1, 4, 1, 1, 0, 0);
        do_reset();
        // Pseudo-random sweep over IDs, targets and handshakes.
        lf = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            bit v, r, cv;
            int id, t, cid, e;
            string tag;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            v   = lf[0] | lf[1];
            r   = lf[2] | lf[9];
            id  = int'(lf[6:3]);
            t   = int'(lf[8:7]);
            cid = int'(lf[14:11]);
            cv  = lf[15] && (m_cnt[cid % NENT] != 0);
            e   = id % NENT;
            if (m_tot == MAXTOT) tag = "R6";
            else if (m_cnt[e] == MAXID) tag = "R3";
            else if (m_cnt[e] != 0 && m_tgt[e] != t) tag = "R2";
            else if (cv && (cid % NENT) == e) tag = "R8";
            else tag = "R5";
            step(tag, v, id, t, r, cv, cid);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule